// File: doc/BRIEF.md
# Dual-Tone Signalling Sample Generator

This block synthesises the digital samples of a two-tone signalling waveform. Two frequency words are held in registers, one for the low-group tone and one for the high-group tone, and each is written through a small register-write port. Each tone owns a phase accumulator. The accumulator advances by that tone's frequency word on every sample strobe, and its top bits address a computed sine table.

The low tone's table holds 6-bit signed amplitudes and the high tone's table holds 7-bit signed amplitudes with a larger peak, which gives the high tone roughly 2 dB more level. Both amplitudes are placed into a 15-bit signed word by the same padding rule. The two words are added with saturation and registered one cycle after the strobe, together with a valid pulse. The registered sample is fanned out to several output ports. Each port has its own enable bit, and a cleared bit forces that port to zero.

Top module: `dtmf_gen`

## Requirements
- R1: After a synchronous active-low reset, both frequency words, both phase accumulators, the output sample and all port enable bits are zero, so every output port reads 0 and `out_vld` is 0.
- R2: A write with `wr_en`=1 stores `wr_data` according to `wr_addr`: 0 sets the low-tone frequency word, 1 sets the high-tone frequency word, and 2 sets the port enables from `wr_data[NUM_OUT-1:0]`. Address 3 changes nothing.
- R3: On every cycle with `sample_stb`=1 and a non-zero frequency word, that tone's 16-bit accumulator advances by the word, modulo 2^16. The table index is accumulator bits [15:10], and the sample uses the index held before the advance.
- R4: The low-tone table entry for index i is s(i, 31), where t = i mod 32, N = 16·t·(32−t), D = 5120 − 4·t·(32−t), m = floor((P·N + D/2)/D), and s = m for i < 32 and −m otherwise. Its peak is +31 at index 16 and −31 at index 48.
- R5: The high-tone table uses the same formula with P = 39, so its peak is +39 at index 16 and −39 at index 48.
- R6: Each signed amplitude a becomes the 15-bit word a·128: sign bits above and seven zero bits below. A low amplitude of +31 gives 0x0F80.
- R7: On the clock edge that samples `sample_stb`=1, the output sample becomes the sum of the two tone words, clamped to the signed 15-bit range, and `out_vld` is 1 for exactly that following cycle. Without a strobe the sample holds its value.
- R8: A frequency word of zero mutes its tone. The tone adds 0 to the sum, and its accumulator is held at zero, so the tone restarts at index 0 when it is later given a non-zero word.
- R9: Port k, bits [15k+14:15k] of `out_data`, shows the current sample when enable bit k is 1 and shows 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 low word, 1 high word, 2 enables) |
| wr_data | input | 16 | Write data |
| sample_stb | input | 1 | Produce one sample and advance both phases |
| out_data | output | NUM_OUT*15 | Gated output ports, 15-bit signed each |
| out_vld | output | 1 | Pulses one cycle after each strobe |

## Verification
A wrong accumulator step or table index shows up as a wrong sample value on the first strobe after the fault. From then on every sample stays wrong, because the phase error never decays. A mute that fails to clear the phase shows up only when the tone is re-enabled, as a first sample that is not zero. A scaling or summing fault shows at peak indices as values other than ±3968, ±4992 or ±8960. A gating fault shows immediately on the affected port, without waiting for a strobe.

// File: rtl/dtmf_pkg.sv
// dtmf_pkg: shared constants and the sine-table formula for the tone generator.
// Assumes callers pass constant arguments so the table folds at elaboration.
package dtmf_pkg;
    localparam int FCW_W  = 16;   // frequency word and accumulator width
    localparam int IDX_W  = 6;    // table index width
    localparam int PAD_W  = 7;    // zero bits below the amplitude
    localparam int WORD_W = 15;   // output sample width
    localparam int LO_AMP_W = 6;
    localparam int HI_AMP_W = 7;
    localparam int LO_PEAK  = 31;
    localparam int HI_PEAK  = 39;

    localparam logic [1:0] ADDR_LO = 2'd0;
    localparam logic [1:0] ADDR_HI = 2'd1;
    localparam logic [1:0] ADDR_EN = 2'd2;

    // Rational sine approximation over one half wave of 'half' steps.
    function automatic int tone_sample(input int idx, input int peak, input int half);
        int t, num, den, mag;
        t   = idx % half;
        num = 16 * t * (half - t);
        den = 5 * half * half - 4 * t * (half - t);
        mag = (peak * num + den / 2) / den;
        return (idx >= half) ? -mag : mag;
    endfunction
endpackage

// File: rtl/dtmf_tone_ch.sv
// dtmf_tone_ch: one tone channel. Holds a phase accumulator, looks up a
// signed amplitude in a computed sine table and pads it into an output word.
// Assumes WORD_W >= AMP_W + PAD_W and that fcw_i comes from a register.
module dtmf_tone_ch
    import dtmf_pkg::*;
#(
    parameter int ACC_W  = FCW_W,
    parameter int TIDX_W = IDX_W,
    parameter int AMP_W  = LO_AMP_W,
    parameter int PEAK   = LO_PEAK,
    parameter int ZPAD_W = PAD_W,
    parameter int OUT_W  = WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb_i,
    input  logic [ACC_W-1:0]        fcw_i,
    output logic signed [OUT_W-1:0] word_o
);
    localparam int ENTRIES = 1 << TIDX_W;
    localparam int HALF    = ENTRIES / 2;
    localparam int EXT_W   = OUT_W - AMP_W - ZPAD_W;

    logic [ACC_W-1:0]        acc_q;
    logic [TIDX_W-1:0]       idx;
    logic signed [AMP_W-1:0] amp;
    logic signed [AMP_W-1:0] rom [ENTRIES];
    logic                    mute;

    // Table contents computed from the package formula, one constant per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
        assign rom[g] = AMP_W'(tone_sample(g, PEAK, HALF));
    end

    assign mute = (fcw_i == '0);

    // Phase accumulator: cleared while muted, advanced on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (mute)  acc_q <= '0;
        else if (stb_i) acc_q <= acc_q + fcw_i;
    end

    // Table look-up and padding into the output word.
    always_comb begin
        idx    = acc_q[ACC_W-1 -: TIDX_W];
        amp    = rom[idx];
        word_o = mute ? '0 : {{EXT_W{amp[AMP_W-1]}}, amp, {ZPAD_W{1'b0}}};
    end

    // R8: a muted tone leaves its phase at zero after a strobe
    p_mute_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mute && stb_i) |=> (acc_q == '0));
    // R3: a live tone moves its phase on every strobe
    p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !mute) |=> (acc_q != $past(acc_q)));
    // R4/R5: word stays inside the padded peak range
    p_peak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(word_o) <= (PEAK << ZPAD_W)) && (int'(word_o) >= -((PEAK + 1) << ZPAD_W)));
endmodule

// File: rtl/dtmf_mixer.sv
// dtmf_mixer: adds the two tone words with saturation and registers the
// result on each sample strobe, raising a one-cycle valid with it.
// Assumes both inputs share the width WORD_W.
module dtmf_mixer
    import dtmf_pkg::*;
#(
    parameter int OUT_W = WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stb_i,
    input  logic signed [OUT_W-1:0] lo_i,
    input  logic signed [OUT_W-1:0] hi_i,
    output logic signed [OUT_W-1:0] mix_o,
    output logic                    vld_o
);
    localparam logic signed [OUT_W:0] S_MAX = {2'b00, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W:0] S_MIN = {2'b11, {(OUT_W-1){1'b0}}};

    logic signed [OUT_W:0]   sum;
    logic signed [OUT_W-1:0] sat;
    logic signed [OUT_W-1:0] mix_q;
    logic                    vld_q;

    // Widened sum clamped back into the output range.
    always_comb begin
        sum = {lo_i[OUT_W-1], lo_i} + {hi_i[OUT_W-1], hi_i};
        if (sum > S_MAX)      sat = S_MAX[OUT_W-1:0];
        else if (sum < S_MIN) sat = S_MIN[OUT_W-1:0];
        else                  sat = sum[OUT_W-1:0];
    end

    // Sample register and valid pulse, loaded on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= stb_i;
            if (stb_i) mix_q <= sat;
        end
    end

    assign mix_o = mix_q;
    assign vld_o = vld_q;

    // R7: sample holds between strobes
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(mix_q));
    // R7: valid only follows a strobe
    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(stb_i));
    // R7: two non-negative words never wrap to a negative sum
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !lo_i[OUT_W-1] && !hi_i[OUT_W-1]) |=> !mix_q[OUT_W-1]);
endmodule

// File: rtl/dtmf_gen.sv
// dtmf_gen: top of the dual-tone sample generator. Holds the frequency and
// enable registers, runs a low and a high tone channel, mixes them and gates
// the shared sample onto NUM_OUT ports.
// Assumes 1 <= NUM_OUT <= 16 and writes that arrive one per cycle.
module dtmf_gen
    import dtmf_pkg::*;
#(
    parameter int NUM_OUT = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_addr,
    input  logic [FCW_W-1:0]            wr_data,
    input  logic                        sample_stb,
    output logic [NUM_OUT*WORD_W-1:0]   out_data,
    output logic                        out_vld
);
    logic [FCW_W-1:0]          fcw_lo_q, fcw_hi_q;
    logic [NUM_OUT-1:0]        en_q;
    logic signed [WORD_W-1:0]  word_lo, word_hi, mix;

    // Register file: two frequency words and the port enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcw_lo_q <= '0;
            fcw_hi_q <= '0;
            en_q     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_LO: fcw_lo_q <= wr_data;
                ADDR_HI: fcw_hi_q <= wr_data;
                ADDR_EN: en_q     <= wr_data[NUM_OUT-1:0];
                default: ;
            endcase
        end
    end

    dtmf_tone_ch #(.AMP_W(LO_AMP_W), .PEAK(LO_PEAK)) u_lo (
        .clk(clk), .rst_n(rst_n), .stb_i(sample_stb), .fcw_i(fcw_lo_q), .word_o(word_lo));

    dtmf_tone_ch #(.AMP_W(HI_AMP_W), .PEAK(HI_PEAK)) u_hi (
        .clk(clk), .rst_n(rst_n), .stb_i(sample_stb), .fcw_i(fcw_hi_q), .word_o(word_hi));

    dtmf_mixer #(.OUT_W(WORD_W)) u_mix (
        .clk(clk), .rst_n(rst_n), .stb_i(sample_stb),
        .lo_i(word_lo), .hi_i(word_hi), .mix_o(mix), .vld_o(out_vld));

    // Per-port gate of the shared sample.
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_port
        assign out_data[k*WORD_W +: WORD_W] = en_q[k] ? mix : '0;

        // R9: any two enabled ports carry the same sample
        p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[k] && en_q[0]) |-> (out_data[k*WORD_W +: WORD_W] == out_data[WORD_W-1:0]));
    end

    // R1: nothing is enabled in the first cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (out_data == '0));
endmodule

// File: tb/dtmf_gen_bench.sv
module dtmf_gen_bench;
    localparam int NP = 3;
    localparam int W  = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [15:0]   wr_data = 16'd0;
    logic          sample_stb = 1'b0;
    logic [NP*W-1:0] out_data;
    logic          out_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // model state
    int m_flo = 0, m_fhi = 0, m_alo = 0, m_ahi = 0, m_en = 0, m_mix = 0, m_vld = 0;

    always #2 clk = ~clk;

    dtmf_gen #(.NUM_OUT(NP)) u_dtmf_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample_stb(sample_stb),
        .out_data(out_data), .out_vld(out_vld));

    // table amplitude from the R4/R5 formula, scaled per R6
    function automatic int tone_word(int acc, int peak);
        int i, t, n, d, m;
        i = acc >> 10;
        t = i % 32;
        n = 16 * t * (32 - t);
        d = 5120 - 4 * t * (32 - t);
        m = (peak * n + d / 2) / d;
        if (i >= 32) m = -m;
        return m * 128;
    endfunction

    function automatic int port_val(int k);
        return int'($signed(out_data[k*W +: W]));
    endfunction

    task automatic check(int act, int exp, string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference model, one step per clock
    always @(posedge clk) begin
        int s, wl, wh;
        if (!rst_n) begin
            m_flo = 0; m_fhi = 0; m_alo = 0; m_ahi = 0; m_en = 0; m_mix = 0; m_vld = 0;
        end else begin
            m_vld = sample_stb ? 1 : 0;
            if (sample_stb) begin
                wl = (m_flo == 0) ? 0 : tone_word(m_alo, 31);
                wh = (m_fhi == 0) ? 0 : tone_word(m_ahi, 39);
                s = wl + wh;
                if (s > 16383) s = 16383;
                if (s < -16384) s = -16384;
                m_mix = s;
            end
            if (m_flo == 0) m_alo = 0; else if (sample_stb) m_alo = (m_alo + m_flo) & 16'hFFFF;
            if (m_fhi == 0) m_ahi = 0; else if (sample_stb) m_ahi = (m_ahi + m_fhi) & 16'hFFFF;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_flo = int'(wr_data);
                    2'd1: m_fhi = int'(wr_data);
                    2'd2: m_en  = int'(wr_data[NP-1:0]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(int'(out_vld), m_vld, "R7 valid");
            for (int k = 0; k < NP; k++)
                check(port_val(k), m_en[k] ? m_mix : 0, "R3 R4 R5 R6 R8 R9 model port");
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(int port, int exp, string tag);
        @(negedge clk);
        sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        check(port_val(port), exp, tag);
        check(int'(out_vld), 1, "R7 valid after strobe");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int k = 0; k < NP; k++) check(port_val(k), 0, "R1 port after reset");
        check(int'(out_vld), 0, "R1 valid after reset");

        wr(2'd2, 16'h0007);
        wr(2'd0, 16'h4000);
        pulse(0, 0, "R4 low index 0");
        pulse(0, 3968, "R4 R6 low peak 0x0F80");
        pulse(0, 0, "R4 low index 32");
        pulse(0, -3968, "R4 low trough");

        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h4000);
        pulse(0, 0, "R8 R5 high index 0, low muted");
        pulse(0, 4992, "R5 high peak");
        pulse(0, 0, "R5 high index 32");
        pulse(0, -4992, "R5 high trough");

        wr(2'd0, 16'h4000);
        pulse(0, 0, "R8 low restarts at index 0");
        pulse(0, 8960, "R7 sum of peaks");
        pulse(0, 0, "R7 sum zero");
        pulse(0, -8960, "R7 sum of troughs");

        wr(2'd2, 16'h0002);
        pulse(1, 0, "R9 enabled port");
        pulse(1, 8960, "R9 enabled port peak");
        check(port_val(0), 0, "R9 disabled port 0");
        check(port_val(2), 0, "R9 disabled port 2");

        repeat (5) @(negedge clk);
        check(port_val(1), 8960, "R7 hold without strobe");
        check(int'(out_vld), 0, "R7 no valid without strobe");

        wr(2'd3, 16'h1234);
        check(port_val(1), 8960, "R2 address 3 leaves output");
        pulse(1, 0, "R2 address 3 leaves words");
        pulse(1, -8960, "R2 R3 phase continues");

        // mixed traffic against the model
        wr(2'd2, 16'h0005);
        wr(2'd0, 16'h0b2d);
        wr(2'd1, 16'h13a7);
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            sample_stb = ($urandom % 3) == 0;
            wr_en = ($urandom % 61) == 0;
            wr_addr = 2'($urandom % 4);
            wr_data = (($urandom % 5) == 0) ? 16'h0000 : 16'($urandom);
        end
        @(negedge clk);
        sample_stb = 1'b0; wr_en = 1'b0;

        // reset in the middle of traffic
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NP; k++) check(port_val(k), 0, "R1 port after second reset");
        pulse(0, 0, "R1 R8 words cleared by reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule